// File: doc/BRIEF.md
# Symbol Error Mask Applier

This block repairs a 512-byte data buffer once an outside Reed-Solomon decoder has found where the errors are. The decoder works on 9-bit symbols and gives up to four error records. Each record holds a 1-based symbol index and a 9-bit error pattern. Symbols are 9 bits wide and the buffer is addressed in bytes, so a symbol can span two neighbouring bytes. The block turns each symbol index into a byte address and a bit offset. It then flips the flagged bits through a byte-wide memory port, with one read followed by one write for every byte it changes.

A single `start` strobe loads all records, the error count and the uncorrectable flag. The count selects how many records are used. They are applied from the highest-numbered record in use down to record 0. Records that point past the end of the buffer are skipped, and so are records with index 0. A pattern that would reach past the last byte is cut off at the last byte. `done` pulses for one cycle when the work is finished, or right away when the decoder reported the block as uncorrectable or gave a count that is out of range.

Top module: `rs_mask_apply`

## Requirements
- R1: When `uncorr` is 1 on an accepted `start`, the block makes no memory read or write, and `done` is high in the cycle right after the start edge.
- R2: An `err_cnt` of 0 or of more than 4 on an accepted `start` has the same effect as R1: no memory access, and `done` in the next cycle.
- R3: With `err_cnt` = N (1 to 4), only records N-1 down to 0 are applied, in that descending order. Record r sits at bits [r*10 +: 10] of `rec_idx` and at bits [r*9 +: 9] of `rec_mask`.
- R4: For index i ≥ 1 with z = i-1, the target byte is z + (z>>3). The pattern is shifted left by z&7, and bits 7:0 of the shifted pattern are XORed into the target byte.
- R5: Bits 15:8 of the shifted pattern are XORed into the byte at target+1.
- R6: A record whose target is 512 or more, or whose index is 0, changes nothing and takes no memory access.
- R7: When the target is byte 511, only byte 511 changes.
- R8: When bits 15:8 of the shifted pattern are zero, the block does not access byte target+1. Each applied record takes 3 cycles, plus 2 when the upper byte is written. Each skipped record takes 1 cycle.
- R9: Each byte update is a read (`mem_rd_en`, one-cycle read latency) followed in the next cycle by a write to the same address. The write uses the data just read, so two records that hit the same byte both take effect.
- R10: `done` is a one-cycle pulse, and `busy` is high from the start edge until `done` has been seen. A `start` that arrives while busy is ignored, and so are record inputs that change after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load the records and begin correction |
| uncorr | input | 1 | Decoder reported the block as uncorrectable |
| err_cnt | input | 3 | Number of records to apply |
| rec_idx | input | 40 | Four 10-bit 1-based symbol indices |
| rec_mask | input | 36 | Four 9-bit error patterns |
| mem_rd_en | output | 1 | Buffer read strobe |
| mem_wr_en | output | 1 | Buffer write strobe |
| mem_addr | output | 9 | Buffer byte address |
| mem_wdata | output | 8 | Corrected byte to write |
| mem_rdata | input | 8 | Buffer read data, valid one cycle after a read |
| busy | output | 1 | Correction in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong record pointer or a wrong count decode shows up as a write address out of the expected descending order, at the first write after `start`. A wrong shift or a wrong byte mapping leaves a buffer byte that does not match the model, and this is seen as soon as `done` arrives. A stuck flag for the upper byte changes the write count and the cycles from `start` to `done`. A broken read-to-write pairing makes the doubled-hit case leave residue in the byte. All of these are visible within one correction run.

// File: rtl/rs_fix_pkg.sv
package rs_fix_pkg;

  localparam int unsigned FIX_BLK_BYTES = 512;
  localparam int unsigned FIX_IDX_W     = 10;
  localparam int unsigned FIX_SYM_W     = 9;
  localparam int unsigned FIX_NREC      = 4;
  localparam int unsigned FIX_CNT_W     = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVAL,
    ST_RD_LO,
    ST_WR_LO,
    ST_RD_HI,
    ST_WR_HI,
    ST_DONE
  } fix_state_e;

  // byte holding the first bit of symbol idx (1-based)
  function automatic logic [31:0] sym_byte(input logic [31:0] idx);
    logic [31:0] z;
    z = idx - 32'd1;
    return z + (z >> 3);
  endfunction

  // bit offset of that symbol within its first byte
  function automatic logic [2:0] sym_shift(input logic [31:0] idx);
    logic [31:0] z;
    z = idx - 32'd1;
    return z[2:0];
  endfunction

  function automatic logic cnt_ok(input logic [31:0] cnt, input logic [31:0] nrec);
    return (cnt >= 32'd1) && (cnt <= nrec);
  endfunction

endpackage

// File: rtl/rs_rec_store.sv
module rs_rec_store #(
  parameter int unsigned NREC  = 4,
  parameter int unsigned IDX_W = 10,
  parameter int unsigned SYM_W = 9,
  parameter int unsigned SEL_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    capture,
  input  logic [NREC*IDX_W-1:0]   rec_idx,
  input  logic [NREC*SYM_W-1:0]   rec_mask,
  input  logic [SEL_W-1:0]        sel,
  output logic [IDX_W-1:0]        sel_idx,
  output logic [SYM_W-1:0]        sel_mask
);

  logic [IDX_W-1:0] idx_q  [NREC];
  logic [SYM_W-1:0] mask_q [NREC];

  for (genvar r = 0; r < NREC; r++) begin : g_rec
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        idx_q[r]  <= '0;
        mask_q[r] <= '0;
      end else if (capture) begin
        idx_q[r]  <= rec_idx[r*IDX_W +: IDX_W];
        mask_q[r] <= rec_mask[r*SYM_W +: SYM_W];
      end
    end
  end

  always_comb begin
    sel_idx  = idx_q[sel];
    sel_mask = mask_q[sel];
  end

endmodule

// File: rtl/rs_rec_eval.sv
module rs_rec_eval
  import rs_fix_pkg::*;
#(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned SYM_W = 9,
  parameter int unsigned BLK   = 512,
  parameter int unsigned ADDRW = 9
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [SYM_W-1:0] mask,
  output logic             hit,
  output logic [ADDRW-1:0] tgt_addr,
  output logic [7:0]       lo_byte,
  output logic [7:0]       hi_byte,
  output logic             has_hi
);

  logic [31:0] tgt;
  logic [15:0] shifted;

  always_comb begin
    tgt      = sym_byte(32'(idx));
    shifted  = 16'(32'(mask) << sym_shift(32'(idx)));
    hit      = (idx != '0) && (tgt < 32'(BLK));
    tgt_addr = tgt[ADDRW-1:0];
    lo_byte  = shifted[7:0];
    hi_byte  = shifted[15:8];
    has_hi   = hit && (tgt != 32'(BLK - 1)) && (shifted[15:8] != 8'd0);
  end

endmodule

// File: rtl/rs_fix_seq.sv
module rs_fix_seq
  import rs_fix_pkg::*;
#(
  parameter int unsigned NREC  = 4,
  parameter int unsigned CNT_W = 3,
  parameter int unsigned ADDRW = 9,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             uncorr,
  input  logic [CNT_W-1:0] err_cnt,
  input  logic             hit,
  input  logic [ADDRW-1:0] tgt_addr,
  input  logic [7:0]       lo_byte,
  input  logic [7:0]       hi_byte,
  input  logic             has_hi,
  input  logic [7:0]       mem_rdata,
  output logic [SEL_W-1:0] sel,
  output logic             capture,
  output logic             mem_rd_en,
  output logic             mem_wr_en,
  output logic [ADDRW-1:0] mem_addr,
  output logic [7:0]       mem_wdata,
  output logic             busy,
  output logic             done,
  output logic             hi_phase
);

  fix_state_e       state;
  logic [SEL_W-1:0] cur;
  logic [ADDRW-1:0] lo_addr;
  logic [7:0]       lo_q;
  logic [7:0]       hi_q;
  logic             hi_need;
  logic             suppress;
  logic             last_rec;

  assign suppress = uncorr || !cnt_ok(32'(err_cnt), 32'(NREC));
  assign last_rec = (cur == '0);
  assign capture  = start && (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cur     <= '0;
      lo_addr <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      hi_need <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (suppress) begin
              state <= ST_DONE;
            end else begin
              cur   <= SEL_W'(err_cnt - CNT_W'(1));
              state <= ST_EVAL;
            end
          end
        end
        ST_EVAL: begin
          if (hit) begin
            lo_addr <= tgt_addr;
            lo_q    <= lo_byte;
            hi_q    <= hi_byte;
            hi_need <= has_hi;
            state   <= ST_RD_LO;
          end else if (last_rec) begin
            state <= ST_DONE;
          end else begin
            cur <= cur - SEL_W'(1);
          end
        end
        ST_RD_LO: state <= ST_WR_LO;
        ST_WR_LO: begin
          if (hi_need) begin
            state <= ST_RD_HI;
          end else if (last_rec) begin
            state <= ST_DONE;
          end else begin
            cur   <= cur - SEL_W'(1);
            state <= ST_EVAL;
          end
        end
        ST_RD_HI: state <= ST_WR_HI;
        ST_WR_HI: begin
          if (last_rec) begin
            state <= ST_DONE;
          end else begin
            cur   <= cur - SEL_W'(1);
            state <= ST_EVAL;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    hi_phase  = (state == ST_RD_HI) || (state == ST_WR_HI);
    mem_rd_en = (state == ST_RD_LO) || (state == ST_RD_HI);
    mem_wr_en = (state == ST_WR_LO) || (state == ST_WR_HI);
    mem_addr  = hi_phase ? ADDRW'(lo_addr + ADDRW'(1)) : lo_addr;
    mem_wdata = mem_rdata ^ (hi_phase ? hi_q : lo_q);
    busy      = (state != ST_IDLE);
    done      = (state == ST_DONE);
    sel       = cur;
  end

endmodule

// File: rtl/rs_mask_apply.sv
module rs_mask_apply
  import rs_fix_pkg::*;
#(
  parameter int unsigned NREC  = FIX_NREC,
  parameter int unsigned IDX_W = FIX_IDX_W,
  parameter int unsigned SYM_W = FIX_SYM_W,
  parameter int unsigned BLK   = FIX_BLK_BYTES,
  parameter int unsigned CNT_W = FIX_CNT_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  uncorr,
  input  logic [CNT_W-1:0]      err_cnt,
  input  logic [NREC*IDX_W-1:0] rec_idx,
  input  logic [NREC*SYM_W-1:0] rec_mask,
  output logic                  mem_rd_en,
  output logic                  mem_wr_en,
  output logic [$clog2(BLK)-1:0] mem_addr,
  output logic [7:0]            mem_wdata,
  input  logic [7:0]            mem_rdata,
  output logic                  busy,
  output logic                  done
);

  localparam int unsigned ADDRW = $clog2(BLK);
  localparam int unsigned SEL_W = (NREC > 1) ? $clog2(NREC) : 1;

  logic [SEL_W-1:0] sel;
  logic             capture;
  logic [IDX_W-1:0] sel_idx;
  logic [SYM_W-1:0] sel_mask;
  logic             hit;
  logic [ADDRW-1:0] tgt_addr;
  logic [7:0]       lo_byte;
  logic [7:0]       hi_byte;
  logic             has_hi;
  logic             hi_phase;

  rs_rec_store #(
    .NREC(NREC), .IDX_W(IDX_W), .SYM_W(SYM_W), .SEL_W(SEL_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .capture(capture),
    .rec_idx(rec_idx), .rec_mask(rec_mask), .sel(sel),
    .sel_idx(sel_idx), .sel_mask(sel_mask)
  );

  rs_rec_eval #(
    .IDX_W(IDX_W), .SYM_W(SYM_W), .BLK(BLK), .ADDRW(ADDRW)
  ) u_eval (
    .idx(sel_idx), .mask(sel_mask), .hit(hit), .tgt_addr(tgt_addr),
    .lo_byte(lo_byte), .hi_byte(hi_byte), .has_hi(has_hi)
  );

  rs_fix_seq #(
    .NREC(NREC), .CNT_W(CNT_W), .ADDRW(ADDRW), .SEL_W(SEL_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .uncorr(uncorr),
    .err_cnt(err_cnt), .hit(hit), .tgt_addr(tgt_addr),
    .lo_byte(lo_byte), .hi_byte(hi_byte), .has_hi(has_hi),
    .mem_rdata(mem_rdata), .sel(sel), .capture(capture),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy), .done(done), .hi_phase(hi_phase)
  );

endmodule

// File: rtl/rs_fix_checker.sv
module rs_fix_checker #(
  parameter int unsigned NREC  = 4,
  parameter int unsigned CNT_W = 3,
  parameter int unsigned ADDRW = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             uncorr,
  input logic [CNT_W-1:0] err_cnt,
  input logic             mem_rd_en,
  input logic             mem_wr_en,
  input logic [ADDRW-1:0] mem_addr,
  input logic             busy,
  input logic             done,
  input logic             hi_phase
);

  assert_suppress_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && uncorr) |=> (done && !mem_rd_en && !mem_wr_en));

  assert_badcnt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && ((err_cnt == '0) || (32'(err_cnt) > NREC))) |=> done);

  assert_hi_adjacent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && hi_phase) |-> (mem_addr == ADDRW'($past(mem_addr, 2) + ADDRW'(1))));

  assert_rmw_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> ($past(mem_rd_en) && (mem_addr == $past(mem_addr))));

  assert_no_rdwr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

endmodule

bind rs_mask_apply rs_fix_checker #(
  .NREC(NREC), .CNT_W(CNT_W), .ADDRW($clog2(BLK))
) u_fix_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .uncorr(uncorr),
  .err_cnt(err_cnt), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
  .mem_addr(mem_addr), .busy(busy), .done(done), .hi_phase(hi_phase)
);

// File: tb/rs_mask_apply_bench.sv
`timescale 1ns/1ps
module rs_mask_apply_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        uncorr = 1'b0;
  logic [2:0]  err_cnt = '0;
  logic [39:0] rec_idx = '0;
  logic [35:0] rec_mask = '0;
  logic        mem_rd_en, mem_wr_en, busy, done;
  logic [8:0]  mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  int errors = 0;
  int checks = 0;

  logic [7:0] mem [512];
  int exp_mem [512];
  int wlog [16];
  int wn = 0;
  int ew [16];
  int en;
  int lat;
  int t_idx [4];
  int t_mask [4];

  always #5 clk = ~clk;

  rs_mask_apply u_rs_mask_apply (
    .clk(clk), .rst_n(rst_n), .start(start), .uncorr(uncorr),
    .err_cnt(err_cnt), .rec_idx(rec_idx), .rec_mask(rec_mask),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
    if (mem_wr_en) begin
      mem[mem_addr] <= mem_wdata;
      if (wn < 16) wlog[wn] = int'(mem_addr);
      wn = wn + 1;
    end
  end

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // reference: bit position of symbol z is 9*z, so its byte is 9*z/8
  task automatic model(input bit unc, input int cnt);
    for (int b = 0; b < 512; b++) exp_mem[b] = int'(mem[b]);
    en = 0; lat = 0;
    if (unc || cnt < 1 || cnt > 4) return;
    for (int r = cnt - 1; r >= 0; r--) begin
      int z, byt, sh;
      if (t_idx[r] == 0) begin lat += 1; continue; end
      z = t_idx[r] - 1;
      byt = (z * 9) / 8;
      if (byt >= 512) begin lat += 1; continue; end
      sh = (t_mask[r] << (z % 8));
      exp_mem[byt] = exp_mem[byt] ^ (sh & 255);
      ew[en] = byt; en++; lat += 3;
      if (byt < 511 && ((sh >> 8) & 255) != 0) begin
        exp_mem[byt+1] = exp_mem[byt+1] ^ ((sh >> 8) & 255);
        ew[en] = byt + 1; en++; lat += 2;
      end
    end
  endtask

  task automatic run(input bit unc, input int cnt, input string req, input bit poke);
    int n, mism;
    model(unc, cnt);
    @(negedge clk);
    for (int r = 0; r < 4; r++) begin
      rec_idx[r*10 +: 10] = 10'(t_idx[r]);
      rec_mask[r*9 +: 9]  = 9'(t_mask[r]);
    end
    uncorr = unc; err_cnt = 3'(cnt); start = 1'b1; wn = 0;
    @(posedge clk); #1;
    start = 1'b0;
    n = 0;
    while (!done && n < 100) begin
      if (poke && n == 1) begin
        start = 1'b1; uncorr = 1'b1; rec_idx = '0; rec_mask = '1;
      end else begin
        start = 1'b0;
      end
      @(posedge clk); #1;
      n++;
    end
    start = 1'b0;
    if (n >= 100) begin
      checks++; errors++;
      $display("FAIL %s actual=timeout expected=done", req);
    end
    check({req, " R8 cycles"}, n, lat);
    @(posedge clk); #1;
    check("R10 done pulse width", int'(done), 0);
    check("R10 busy after done", int'(busy), 0);
    mism = 0;
    for (int b = 0; b < 512; b++) if (int'(mem[b]) != exp_mem[b]) mism++;
    check({req, " buffer mismatches"}, mism, 0);
    check({req, " R9 write count"}, wn, en);
    for (int k = 0; k < en && k < wn; k++) check({req, " R3 write order"}, wlog[k], ew[k]);
  endtask

  initial begin : watchdog
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int b = 0; b < 512; b++) mem[b] = 8'($urandom);
    repeat (3) @(posedge clk);
    #1;
    check("reset done", int'(done), 0);
    check("reset busy", int'(busy), 0);
    check("reset rd/wr", int'(mem_rd_en) + int'(mem_wr_en), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R4: index 1, bit 0 of byte 0
    t_idx = '{1, 0, 0, 0}; t_mask = '{1, 0, 0, 0};
    run(0, 1, "R4 first bit", 0);
    // R8: upper byte zero, no second access
    t_idx = '{1, 0, 0, 0}; t_mask = '{8'hff, 0, 0, 0};
    run(0, 1, "R8 no upper write", 0);
    // R5: straddle bytes 7 and 8
    t_idx = '{8, 0, 0, 0}; t_mask = '{9'h1ff, 0, 0, 0};
    run(0, 1, "R5 straddle", 0);
    // R7: target byte 511 clipped
    t_idx = '{456, 0, 0, 0}; t_mask = '{9'h1ff, 0, 0, 0};
    run(0, 1, "R7 last byte", 0);
    // R6: target 513 and index 0 skipped
    t_idx = '{457, 0, 600, 1023}; t_mask = '{9'h1ff, 9'h1ff, 9'h1ff, 9'h1ff};
    run(0, 4, "R6 out of range", 0);
    // R1: uncorrectable flag
    t_idx = '{3, 9, 20, 40}; t_mask = '{9'h155, 9'h0aa, 9'h1ff, 9'h001};
    run(1, 4, "R1 uncorrectable", 0);
    // R2: counts 0, 5, 7
    run(0, 0, "R2 count zero", 0);
    run(0, 5, "R2 count five", 0);
    run(0, 7, "R2 count seven", 0);
    // R3: descending order with count 3, record 3 left out
    t_idx = '{10, 100, 200, 300}; t_mask = '{9'h1ff, 9'h1ff, 9'h1ff, 9'h1ff};
    run(0, 3, "R3 order", 0);
    // R9: two records on the same symbol cancel
    t_idx = '{5, 5, 0, 0}; t_mask = '{9'h13c, 9'h13c, 0, 0};
    run(0, 2, "R9 same byte twice", 0);
    // R10: start and record changes while busy are ignored
    t_idx = '{30, 60, 90, 120}; t_mask = '{9'h101, 9'h0f0, 9'h00f, 9'h1ff};
    run(0, 4, "R10 busy poke", 1);

    for (int t = 0; t < 150; t++) begin
      int c; bit u;
      for (int r = 0; r < 4; r++) begin
        t_idx[r]  = int'($urandom_range(0, 470));
        t_mask[r] = int'($urandom_range(0, 511));
      end
      c = int'($urandom_range(0, 6));
      u = ($urandom_range(0, 9) == 0);
      run(u, c, "R4 random", 0);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule